// File: doc/BRIEF.md
# Ultra-DMA Operation Control and Status Unit

This unit sits between a processor register bus and an ATA Ultra-DMA engine. It holds the operation register, which has an enable bit and a direction bit. It also holds a small register that drives the four active-low bus strobes (two chip selects, read strobe and write strobe). A status word reports live engine signals and sticky error flags.

The unit does not accept a single write that both picks a direction and starts the engine. Software must first write the direction with the enable bit clear. It must then read the operation register. Only after that does a write with the enable bit set start the engine. Stopping the engine clears the operation register and drives all bus strobes high.

The burst protocol, the data FIFOs and the external DMA controller are not part of this unit. They appear only as single-bit event inputs: busy, DMA request, fault, one 32-bit word moved, and a burst that ended short. A two-bit summary output sorts the current condition into error, interrupt, active or idle, so a driver can poll one field.

Top module: `udma_opctl`

## Requirements
- R1: After reset the operation register reads 0, the status word reads 0, the strobe register and the `ide_pins_n` port are 4'hF, and `xfer_state` is 0.
- R2: The operation register is at bus address 0. Bit 0 is the enable and bit 1 is the direction, where 1 means a transfer to the device. Both bits read back on `bus_rdata[1:0]` and appear on `op_en` and `op_to_dev`.
- R3: A write to address 0 with bit 0 set is ignored unless two things came before it, in this order: a write to address 0 with bit 0 clear, then a read of address 0. An ignored write leaves the enable at 0 and the direction unchanged.
- R4: A write to address 0 with bit 0 clear that comes after the read-back cancels that read-back. A new read is then needed before the engine can be enabled.
- R5: When the engine is enabled, a write to address 0 with bit 0 clear stops it. Both operation bits become 0 and `ide_pins_n` returns to 4'hF.
- R6: The strobe register is at bus address 2 and is readable. Bit 0 is chip select 0, bit 1 is chip select 1, bit 2 is the read strobe and bit 3 is the write strobe, all active low.
- R7: The status word is at bus address 1. Bit 16 follows `eng_dreq`, bit 17 is the engine fault flag, bit 18 follows `eng_busy`, bit 24 is data-out incomplete, bit 25 is data-in incomplete and bit 26 is length not a multiple of four words. All other bits read 0.
- R8: Error flags (bits 17, 24, 25 and 26) are sticky. They are cleared only by a write to address 0 with bit 0 clear.
- R9: While the engine is enabled, a pulse on `eng_short` sets bit 24 if the direction is 1 and bit 25 if the direction is 0. A pulse on `eng_fault` sets bit 17.
- R10: When `eng_busy` falls while the engine is enabled, bit 26 is set if the number of words counted since the last evaluation is not a multiple of 4. The count is then cleared.
- R11: `eng_word` pulses are counted only while the engine is enabled.
- R12: `xfer_state` is 3 (error) when any error flag is set. Otherwise it is 2 (interrupt) when `dev_intrq` is high. Otherwise it is 1 (active) when `eng_busy` or `eng_dreq` is high. Otherwise it is 0 (idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 operation, 1 status, 2 strobes |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| eng_busy | input | 1 | Engine busy (not idle) |
| eng_dreq | input | 1 | Engine DMA request |
| eng_fault | input | 1 | Engine state-machine fault pulse |
| eng_word | input | 1 | One 32-bit word moved |
| eng_short | input | 1 | Burst ended before completion |
| dev_intrq | input | 1 | Device interrupt line |
| op_en | output | 1 | Engine enable |
| op_to_dev | output | 1 | Direction, 1 means to the device |
| ide_pins_n | output | 4 | Active-low bus strobes |
| xfer_state | output | 2 | 0 idle, 1 active, 2 interrupt, 3 error |

## Verification
The enable sequence is tried in three orders: enable with no prior direction write, enable after a direction write but with no read, and enable after a direction write that follows the read-back. Each of these must leave the engine off. The correct order is then shown to start it. Word counts of 4, 5 and 3+4 are used. The 3+4 case has 3 words before enabling and 4 after, so a design that counts while disabled would see 7 and raise the length flag; 4 and 5 check the divisibility test itself. The summary output is driven through interrupt alone, interrupt with busy, and interrupt with an error. This separates a correct priority order from a reversed one.

// File: rtl/udma_opctl.sv
module udma_opctl #(
  parameter int WORD_GROUP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [3:0]  bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        eng_busy,
  input  logic        eng_dreq,
  input  logic        eng_fault,
  input  logic        eng_word,
  input  logic        eng_short,
  input  logic        dev_intrq,
  output logic        op_en,
  output logic        op_to_dev,
  output logic [3:0]  ide_pins_n,
  output logic [1:0]  xfer_state
);
  localparam int CW = $clog2(WORD_GROUP);
  localparam logic [1:0] A_OP = 2'd0, A_STS = 2'd1, A_PIN = 2'd2;

  logic [1:0]    arm;
  logic          busy_q;
  logic [CW-1:0] wcnt;
  logic          f_int, f_ndo, f_ndi, f_n4x;

  wire op_wr  = bus_wr && bus_addr == A_OP;
  wire op_rd  = bus_rd && bus_addr == A_OP;
  wire pin_wr = bus_wr && bus_addr == A_PIN;
  wire clr    = op_wr && !bus_wdata[0];
  wire stop   = clr && op_en;
  wire go     = op_wr && bus_wdata[0] && !op_en && arm == 2'd2;
  wire cnt_inc = op_en && eng_word;
  wire [CW-1:0] wnext = wcnt + CW'(cnt_inc);
  wire idle_evt = busy_q && !eng_busy && op_en;
  wire any_err  = f_int | f_ndo | f_ndi | f_n4x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_en <= 1'b0;
      op_to_dev <= 1'b0;
      arm <= 2'd0;
      ide_pins_n <= 4'hF;
    end else begin
      if (clr) begin
        op_en <= 1'b0;
        op_to_dev <= stop ? 1'b0 : bus_wdata[1];
        arm <= stop ? 2'd0 : 2'd1;
      end else if (go) begin
        op_en <= 1'b1;
        op_to_dev <= bus_wdata[1];
        arm <= 2'd0;
      end else if (op_rd && arm == 2'd1) begin
        arm <= 2'd2;
      end
      if (stop) ide_pins_n <= 4'hF;
      else if (pin_wr) ide_pins_n <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wcnt <= '0;
      {f_int, f_ndo, f_ndi, f_n4x} <= 4'b0;
    end else begin
      busy_q <= eng_busy;
      if (clr) begin
        wcnt <= '0;
        {f_int, f_ndo, f_ndi, f_n4x} <= 4'b0;
      end else begin
        wcnt <= idle_evt ? '0 : wnext;
        if (idle_evt && wnext != '0) f_n4x <= 1'b1;
        if (op_en && eng_fault) f_int <= 1'b1;
        if (op_en && eng_short && op_to_dev) f_ndo <= 1'b1;
        if (op_en && eng_short && !op_to_dev) f_ndi <= 1'b1;
      end
    end
  end

  wire [31:0] sts = {5'b0, f_n4x, f_ndi, f_ndo, 5'b0, eng_busy, f_int, eng_dreq, 16'b0};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_OP:    bus_rdata = {30'b0, op_to_dev, op_en};
        A_STS:   bus_rdata = sts;
        A_PIN:   bus_rdata = {28'b0, ide_pins_n};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign xfer_state = any_err ? 2'd3 : dev_intrq ? 2'd2 :
                      (eng_busy | eng_dreq) ? 2'd1 : 2'd0;

  AST_UEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_en) |-> $past(op_wr && bus_wdata[0] && arm == 2'd2)); // R3
  AST_BLIND_UEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && bus_wdata[0] && !op_en && arm != 2'd2) |=> !op_en); // R3
  AST_STOP_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (ide_pins_n == 4'hF && !op_en && !op_to_dev)); // R5
  AST_N4X_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (f_n4x && !clr) |=> f_n4x); // R8
  AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> xfer_state != 2'd0); // R12
endmodule

// File: tb/udma_opctl_tb.sv
`timescale 1ns/1ps
module udma_opctl_tb;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [3:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic eng_busy = 0, eng_dreq = 0, eng_fault = 0, eng_word = 0, eng_short = 0, dev_intrq = 0;
  logic op_en, op_to_dev;
  logic [3:0] ide_pins_n;
  logic [1:0] xfer_state;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  udma_opctl u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_dreq(eng_dreq), .eng_fault(eng_fault),
    .eng_word(eng_word), .eng_short(eng_short), .dev_intrq(dev_intrq),
    .op_en(op_en), .op_to_dev(op_to_dev), .ide_pins_n(ide_pins_n),
    .xfer_state(xfer_state));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pulse_word(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eng_word = 1;
      @(negedge clk); eng_word = 0;
    end
  endtask

  task automatic enable(input logic dir);
    logic [31:0] d;
    wr(0, {2'b0, dir, 1'b0});
    rd(0, d);
    wr(0, {2'b0, dir, 1'b1});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); check("R1 op", d, 0);
    rd(1, d); check("R1 status", d, 0);
    rd(2, d); check("R1 strobe reg", d, 32'hF);
    check("R1 pins", ide_pins_n, 4'hF);
    check("R1 state", xfer_state, 0);
  endtask

  task automatic t_order;
    logic [31:0] d;
    wr(0, 4'b0011); check("R3 blind enable", op_en, 0);
    wr(0, 4'b0010);
    wr(0, 4'b0011); check("R3 enable without read", op_en, 0);
    rd(0, d); check("R3 direction kept, enable 0", d, 32'h2);
    wr(0, 4'b0011);
    rd(0, d); check("R2 op readback", d, 32'h3);
    check("R2 ports", {op_to_dev, op_en}, 2'b11);
  endtask

  task automatic t_rearm;
    logic [31:0] d;
    wr(0, 4'b0000); check("R5 stop clears op", {op_to_dev, op_en}, 0);
    wr(0, 4'b0000); rd(0, d);
    wr(0, 4'b0010);
    wr(0, 4'b0001); check("R4 rewrite cancels readback", op_en, 0);
    rd(0, d); check("R4 direction from rewrite", d, 32'h2);
    wr(0, 4'b0001); check("R4 enable after new read", op_en, 1);
    check("R2 direction from enabling write", op_to_dev, 0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(2, 4'b0101);
    rd(2, d); check("R6 strobe reg readback", d, 32'h5);
    check("R6 pins follow reg", ide_pins_n, 4'b0101);
    wr(0, 4'b0000);
    check("R5 pins high after stop", ide_pins_n, 4'hF);
    rd(0, d); check("R5 op zero after stop", d, 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    enable(1'b1);
    @(negedge clk); eng_busy = 1; eng_dreq = 1;
    rd(1, d); check("R7 busy and dreq bits", d, 32'h0005_0000);
    check("R12 active", xfer_state, 1);
    @(negedge clk); eng_busy = 0; eng_dreq = 0;
    pulse_word(4);
    wr(0, 4'b0000);
  endtask

  task automatic t_errors;
    logic [31:0] d;
    enable(1'b1);
    @(negedge clk); eng_short = 1; @(negedge clk); eng_short = 0;
    rd(1, d); check("R9 data-out incomplete bit 24", d, 32'h0100_0000);
    check("R12 error", xfer_state, 3);
    repeat (3) @(negedge clk);
    rd(1, d); check("R8 flag sticky", d, 32'h0100_0000);
    wr(0, 4'b0000);
    rd(1, d); check("R8 cleared by op write", d, 0);
    enable(1'b0);
    @(negedge clk); eng_short = 1; eng_fault = 1; @(negedge clk); eng_short = 0; eng_fault = 0;
    rd(1, d); check("R9 data-in incomplete and fault", d, 32'h0202_0000);
    wr(0, 4'b0000);
    @(negedge clk); eng_fault = 1; eng_short = 1; @(negedge clk); eng_fault = 0; eng_short = 0;
    rd(1, d); check("R9 ignored while disabled", d, 0);
  endtask

  task automatic burst(input int n);
    @(negedge clk); eng_busy = 1;
    pulse_word(n);
    @(negedge clk); eng_busy = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_length;
    logic [31:0] d;
    enable(1'b0);
    burst(4);
    rd(1, d); check("R10 four words no flag", d, 0);
    burst(5);
    rd(1, d); check("R10 five words flag bit 26", d, 32'h0400_0000);
    wr(0, 4'b0000);
    wr(0, 4'b0000);
    pulse_word(3);
    rd(0, d); wr(0, 4'b0001);
    burst(4);
    rd(1, d); check("R11 words while disabled not counted", d, 0);
    wr(0, 4'b0000);
  endtask

  task automatic t_summary;
    logic [31:0] d;
    @(negedge clk); dev_intrq = 1; #1;
    check("R12 interrupt", xfer_state, 2);
    eng_busy = 1; #1;
    check("R12 interrupt over active", xfer_state, 2);
    eng_busy = 0; dev_intrq = 0;
    enable(1'b1);
    @(negedge clk); eng_short = 1; dev_intrq = 1; @(negedge clk); eng_short = 0; #1;
    check("R12 error over interrupt", xfer_state, 3);
    wr(0, 4'b0000); dev_intrq = 0; #1;
    check("R12 idle", xfer_state, 0);
    rd(1, d); check("R12 status clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_order; t_rearm; t_stop; t_status; t_errors; t_length; t_summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule